// File: doc/BRIEF.md
# Hierarchical Master Interrupt Aggregator

This block folds the pending vectors of eleven lower-level interrupt groups into one 32-bit master interrupt register and decides when a message interrupt should be sent. The groups are four engine groups, three display-pipe groups, one display-port group, one display-miscellaneous group, one platform-controller group and one power-unit group. Each mapped master bit summarises one group, or one 16-bit half of an engine group: it is 1 when any bit of that group under a fixed mask is pending. Only the top bit of the master register can be written. It is the global interrupt enable.

An evaluation starts on a master register write, on a recheck strobe from any lower group, or when a new event has been latched. If the global enable is set at that point, every summary bit is reloaded from the current group state. Bits are set and cleared in the same pass. If the reloaded summary shows anything pending, a one-cycle request pulse is issued. If the enable is clear, the evaluation is skipped: the summary bits keep their old values and no request is made.

Top module: `master_irq_agg`

## Requirements
- R1: After reset the master register reads 0, so the global enable is off, and the request output is 0.
- R2: A master write sets master bit 31 to bit 31 of the write data. Bits 30:0 of the write data are ignored.
- R3: Engine group g (g = 0..3) occupies `grp_pend_i[g*32 +: 32]`. Its bits 15:0 summarise into master bit 2g. Bits 31:16 of groups 0 and 1 summarise into master bits 1 and 3. Bits 31:16 of groups 2 and 3 feed no master bit.
- R4: The pipe groups 4, 5 and 6 (all 32 bits each) summarise into master bits 16, 17 and 18. The port group 7 goes to bit 20, the misc group 8 to bit 22, the platform-controller group 9 to bit 23 and the power-unit group 10 to bit 30.
- R5: An enabled evaluation clears each summary bit whose masked group value is zero, in the same pass that sets the others.
- R6: Master bits 5, 7 to 15, 19, 21 and 24 to 29 always read 0.
- R7: While the enable (after any write in the same cycle) is 0, a trigger leaves bits 30:0 unchanged and no request is made.
- R8: An evaluation is triggered by a master write, by any bit of `grp_recheck_i`, or by `evt_latched_i`. Without a trigger, bits 30:0 hold.
- R9: A request pulse lasts exactly one cycle per evaluation. It appears, together with the updated register, on the clock edge that samples the trigger.
- R10: An enabled evaluation raises the request if and only if the reloaded bits 30:0 are nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| grp_pend_i | input | 352 | Masked pending vectors, group g at [g*32 +: 32] |
| grp_recheck_i | input | 11 | Per-group recheck strobes |
| evt_latched_i | input | 1 | Strobe: a new event was latched in some group |
| mst_wr_i | input | 1 | Master register write strobe |
| mst_wdata_i | input | 32 | Master register write data (only bit 31 used) |
| mst_reg_o | output | 32 | Master register contents |
| irq_req_o | output | 1 | One-cycle interrupt request pulse |

## Verification
Every trigger sampled at a rising edge shows up at that same edge in both `mst_reg_o` and `irq_req_o`, so each result is due exactly one register stage after the stimulus. The driver applies each stimulus at a falling edge and pushes the expected register and pulse values into a queue. The monitor pops one entry a short delay after the next rising edge, so it compares against exactly that cycle's result. Steps that change only the pending vectors, and the idle step after a request, check that nothing moves and that the pulse does not repeat.

// File: rtl/mia_pkg.sv
package mia_pkg;
  localparam int REG_W      = 32;
  localparam int NUM_GROUPS = 11;
  localparam int NUM_MAP    = 13;
  localparam int EN_BIT     = REG_W - 1;

  // Routing table: entry k takes group map_grp(k), masks it, lands on map_pos(k)
  function automatic int map_grp(input int k);
    case (k)
      0, 1:    return 0;
      2, 3:    return 1;
      4:       return 2;
      5:       return 3;
      default: return k - 2;  // 6..12 -> groups 4..10
    endcase
  endfunction

  function automatic int map_pos(input int k);
    case (k)
      0: return 0;   1: return 1;   2: return 2;   3: return 3;
      4: return 4;   5: return 6;   6: return 16;  7: return 17;
      8: return 18;  9: return 20;  10: return 22; 11: return 23;
      default: return 30;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] map_mask(input int k);
    case (k)
      0, 2, 4, 5: return 32'h0000_FFFF;
      1, 3:       return 32'hFFFF_0000;
      default:    return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] mapped_bits();
    logic [REG_W-1:0] m;
    m = '0;
    for (int k = 0; k < NUM_MAP; k++) m[map_pos(k)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/mia_group_reduce.sv
module mia_group_reduce
  import mia_pkg::*;
#(
  parameter int GROUPS = NUM_GROUPS,
  parameter int W      = REG_W,
  parameter int NMAP   = NUM_MAP
) (
  input  logic [GROUPS*W-1:0] pend_i,
  output logic [W-1:0]        summary_o
);
  logic [NMAP-1:0] hit;

  for (genvar k = 0; k < NMAP; k++) begin : g_route
    localparam int G = map_grp(k);
    localparam logic [W-1:0] M = map_mask(k);
    assign hit[k] = |(pend_i[G*W +: W] & M);
  end

  always_comb begin
    summary_o = '0;
    for (int k = 0; k < NMAP; k++) summary_o[map_pos(k)] = summary_o[map_pos(k)] | hit[k];
  end
endmodule

// File: rtl/mia_eval_ctrl.sv
module mia_eval_ctrl
  import mia_pkg::*;
#(
  parameter int GROUPS = NUM_GROUPS,
  parameter int W      = REG_W
) (
  input  logic              wr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [GROUPS-1:0] recheck_i,
  input  logic              evt_i,
  input  logic              en_q_i,
  output logic              en_next_o,
  output logic              do_eval_o
);
  logic trig;
  logic unused_wbits;

  assign unused_wbits = &{1'b0, wdata_i[W-2:0]};
  assign en_next_o    = wr_i ? wdata_i[W-1] : en_q_i;
  assign trig         = wr_i | (|recheck_i) | evt_i;
  assign do_eval_o    = trig & en_next_o;
endmodule

// File: rtl/mia_master_reg.sv
module mia_master_reg
  import mia_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         do_eval_i,
  input  logic         en_next_i,
  input  logic [W-1:0] summary_i,
  output logic [W-1:0] mst_q_o,
  output logic         irq_q_o
);
  localparam int SUM_W = W - 1;

  logic [SUM_W-1:0] sum_q;
  logic             en_q;
  logic             unused_top;

  assign unused_top = summary_i[W-1];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sum_q   <= '0;
      en_q    <= 1'b0;
      irq_q_o <= 1'b0;
    end else begin
      en_q <= en_next_i;
      if (do_eval_i) begin
        sum_q   <= summary_i[SUM_W-1:0];
        irq_q_o <= |summary_i[SUM_W-1:0];
      end else begin
        irq_q_o <= 1'b0;
      end
    end
  end

  assign mst_q_o = {en_q, sum_q};
endmodule

// File: rtl/master_irq_agg.sv
module master_irq_agg
  import mia_pkg::*;
#(
  parameter int GROUPS = NUM_GROUPS,
  parameter int W      = REG_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [GROUPS*W-1:0] grp_pend_i,
  input  logic [GROUPS-1:0] grp_recheck_i,
  input  logic              evt_latched_i,
  input  logic              mst_wr_i,
  input  logic [W-1:0]      mst_wdata_i,
  output logic [W-1:0]      mst_reg_o,
  output logic              irq_req_o
);
  logic [W-1:0] summary;
  logic         en_next;
  logic         do_eval;

  mia_group_reduce #(.GROUPS(GROUPS), .W(W), .NMAP(NUM_MAP)) u_reduce (
    .pend_i    (grp_pend_i),
    .summary_o (summary)
  );

  mia_eval_ctrl #(.GROUPS(GROUPS), .W(W)) u_ctrl (
    .wr_i      (mst_wr_i),
    .wdata_i   (mst_wdata_i),
    .recheck_i (grp_recheck_i),
    .evt_i     (evt_latched_i),
    .en_q_i    (mst_reg_o[W-1]),
    .en_next_o (en_next),
    .do_eval_o (do_eval)
  );

  mia_master_reg #(.W(W)) u_reg (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .do_eval_i (do_eval),
    .en_next_i (en_next),
    .summary_i (summary),
    .mst_q_o   (mst_reg_o),
    .irq_q_o   (irq_req_o)
  );
endmodule

// File: rtl/mia_checker.sv
module mia_checker
  import mia_pkg::*;
#(
  parameter int GROUPS = NUM_GROUPS,
  parameter int W      = REG_W
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [GROUPS-1:0] grp_recheck_i,
  input logic              evt_latched_i,
  input logic              mst_wr_i,
  input logic [W-1:0]      mst_wdata_i,
  input logic [W-1:0]      mst_reg_o,
  input logic              irq_req_o
);
  localparam logic [W-1:0] LEGAL = mapped_bits() | (1 << (W - 1));
  logic trig;
  assign trig = mst_wr_i | (|grp_recheck_i) | evt_latched_i;

  // R6
  p_unmapped_zero_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (mst_reg_o & ~LEGAL) == '0);
  // R2
  p_enable_write_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    mst_wr_i |=> mst_reg_o[W-1] == $past(mst_wdata_i[W-1]));
  // R7
  p_no_req_disabled_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_req_o |-> mst_reg_o[W-1]);
  p_hold_disabled_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (!mst_wr_i && !mst_reg_o[W-1]) |=> $stable(mst_reg_o[W-2:0]) && !irq_req_o);
  // R8
  p_hold_no_trigger_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !trig |=> $stable(mst_reg_o) && !irq_req_o);
  // R10
  p_req_has_pending_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_req_o |-> (mst_reg_o[W-2:0] != '0));
endmodule

bind master_irq_agg mia_checker #(.GROUPS(GROUPS), .W(W)) chk_i (
  .clk_i         (clk_i),
  .rst_i         (rst_i),
  .grp_recheck_i (grp_recheck_i),
  .evt_latched_i (evt_latched_i),
  .mst_wr_i      (mst_wr_i),
  .mst_wdata_i   (mst_wdata_i),
  .mst_reg_o     (mst_reg_o),
  .irq_req_o     (irq_req_o)
);

// File: tb/master_irq_agg_tb.sv
module master_irq_agg_tb_top;
  localparam int G = 11;
  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [G*W-1:0] pend = '0;
  logic [G-1:0]   rech = '0;
  logic           evt  = 1'b0;
  logic           wr   = 1'b0;
  logic [W-1:0]   wdata = '0;
  logic [W-1:0]   mst;
  logic           irq;

  int errors = 0;
  int checks = 0;

  logic [W-1:0] q_mst[$];
  logic         q_irq[$];
  string        q_tag[$];

  logic         m_en = 1'b0;
  logic [30:0]  m_sum = '0;

  always #10 clk = ~clk;

  master_irq_agg dut_i (
    .clk_i(clk), .rst_i(rst), .grp_pend_i(pend), .grp_recheck_i(rech),
    .evt_latched_i(evt), .mst_wr_i(wr), .mst_wdata_i(wdata),
    .mst_reg_o(mst), .irq_req_o(irq)
  );

  function automatic logic [W-1:0] grp(input logic [G*W-1:0] p, input int g);
    return p[g*W +: W];
  endfunction

  // Expected summary straight from R3/R4
  function automatic logic [30:0] model_sum(input logic [G*W-1:0] p);
    logic [30:0] s;
    s = '0;
    s[0]  = |grp(p, 0)[15:0];
    s[1]  = |grp(p, 0)[31:16];
    s[2]  = |grp(p, 1)[15:0];
    s[3]  = |grp(p, 1)[31:16];
    s[4]  = |grp(p, 2)[15:0];
    s[6]  = |grp(p, 3)[15:0];
    s[16] = |grp(p, 4);
    s[17] = |grp(p, 5);
    s[18] = |grp(p, 6);
    s[20] = |grp(p, 7);
    s[22] = |grp(p, 8);
    s[23] = |grp(p, 9);
    s[30] = |grp(p, 10);
    return s;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] em, input logic ei);
    checks++;
    if (mst !== em || irq !== ei) begin
      errors++;
      $display("FAIL %s: mst=%h irq=%b expected mst=%h irq=%b", tag, mst, irq, em, ei);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result
  task automatic step(input logic w, input logic [W-1:0] d, input logic [G-1:0] r,
                      input logic e, input logic [G*W-1:0] p, input string tag);
    logic en_n, trig, ei;
    @(negedge clk);
    wr = w; wdata = d; rech = r; evt = e; pend = p;
    trig = w | (|r) | e;
    en_n = w ? d[31] : m_en;
    ei = 1'b0;
    if (trig && en_n) begin
      m_sum = model_sum(p);
      ei = |m_sum;
    end
    m_en = en_n;
    q_mst.push_back({m_en, m_sum});
    q_irq.push_back(ei);
    q_tag.push_back(tag);
  endtask

  // Monitor
  always @(posedge clk) begin
    #2;
    if (q_mst.size() > 0) check(q_tag.pop_front(), q_mst.pop_front(), q_irq.pop_front());
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [G*W-1:0] p;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1 check("R1 reset state", '0, 1'b0);

    p = '0; p[0*W + 3] = 1'b1;
    step(1, 32'h7FFF_FFFF, '0, 0, p, "R2 R7 low bits of write ignored, disabled");
    step(1, 32'h8000_0000, '0, 0, p, "R3 R9 R10 enable write evaluates engine0 low");
    step(0, '0, '0, 0, p, "R9 pulse lasts one cycle");
    p = '0; p[0*W + 20] = 1'b1;
    step(0, '0, '0, 0, p, "R8 pending change without trigger holds");
    step(0, '0, 11'b1, 0, p, "R3 R5 recheck moves engine0 high");
    p = '0; p[1*W + 7] = 1'b1; p[1*W + 31] = 1'b1; p[3*W + 15] = 1'b1;
    step(0, '0, '0, 1, p, "R3 R8 event evaluates engine1 and engine3");
    p = '0; p[2*W + 16] = 1'b1; p[3*W + 31] = 1'b1;
    step(0, '0, 11'h004, 0, p, "R3 R6 R10 unmapped engine halves give nothing");
    p = '0; p[2*W + 0] = 1'b1;
    step(0, '0, '0, 1, p, "R3 engine2 low to bit 4");
    for (int g = 4; g < G; g++) begin
      p = '0; p[g*W + ((g * 5) % 32)] = 1'b1;
      step(0, '0, '0, 1, p, "R4 single display or platform group");
    end
    p = '0;
    for (int g = 4; g < G; g++) p[g*W + 31] = 1'b1;
    step(0, '0, 11'h400, 0, p, "R4 all upper groups together");
    p = '0; p[0*W + 1] = 1'b1;
    step(1, 32'h0000_0000, '0, 0, p, "R7 disable write skips evaluation");
    step(0, '0, 11'h7FF, 1, p, "R7 triggers while disabled hold summary");
    p = '0;
    step(1, 32'hFFFF_FFFF, '0, 0, p, "R5 R10 empty evaluation clears, no request");
    p = '1;
    step(1, 32'h8000_0000, '0, 0, p, "R6 R10 all pending only mapped bits set");
    step(0, '0, '0, 0, p, "R9 idle after request");
    repeat (3) @(posedge clk);
    #5;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule